// File: doc/BRIEF.md
# Virtual-Channel Time-Slot Allocator

This block holds the link time-slot map of a multi-stream transmitter. Each of the 64 entries names the virtual channel that owns that slot; zero means the slot is free, and slot 0 is reserved and never handed out. A caller either asks for a single allocation (a channel number and a slot count), asks for a batch of up to four streams, or asks for the whole map to be wiped. For every allocation the block finds the lowest free slot, checks that enough slots remain above it to end of table, writes the channel number into the consecutive run, and reports where the run starts.

Once the map has changed, the block waits for the far end to report that its copy of the map is updated, then raises an activation trigger and holds it until the far end confirms it. Only then does the operation finish. A failed allocation leaves the map as it was for that request, reports why, and sends no trigger; the map must then be cleared before new allocations are tried. While an operation runs, `busy` is high and new requests are dropped.

Top module: `tslot_alloc`

## Requirements
- R1: After reset every slot reads channel 0, `busy` is 0, `done` is 0 and `act_req` is 0.
- R2: Slot 0 is never allocated: a search only considers slots 1 to 63, and slot 0 always reads 0.
- R3: The start slot of an allocation is the lowest-numbered slot in 1..63 whose entry is 0; it is reported on `start_slot` when `done` pulses.
- R4: A successful request for N slots starting at S writes its channel number into slots S..S+N-1 and leaves every other slot unchanged.
- R5: If 64 − S < N the request fails with `fail_code` = 2, `start_slot` = S, no slot changes and `act_req` never rises.
- R6: If no slot in 1..63 is free the request fails with `fail_code` = 1 and `start_slot` = 0, with no slot changed and no trigger.
- R7: A clear request sets every slot to 0, then runs the trigger handshake of R9.
- R8: A batch request handles the streams whose `strm_en` bit i is set in ascending i, gives stream i channel number i+1 and count `strm_cnt[i*7 +: 7]`, and records each start in `strm_start[i*6 +: 6]`; the first failing stream stops the batch with the codes of R5/R6 and no trigger; disabled streams keep their old `strm_start` field.
- R9: After a successful change `act_req` rises one cycle after `peer_stat[0]` (table updated) is seen high, stays high until `peer_stat[1]` (trigger seen) is high, and `done` pulses in the cycle after that.
- R10: `busy` is high from the cycle after a request is accepted through the `done` cycle; requests presented while `busy` is high have no effect.
- R11: `rd_vc` returns, combinationally, the channel number stored in slot `rd_slot`.
- R12: A request with N = 0 succeeds when a free slot exists, reports its start and writes no slot.
- R13: Requests presented together are taken in the order clear, then batch, then single allocation; the others are dropped. `fail_code` returns to 0 (none) whenever a request is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| alloc_req | input | 1 | Single allocation request |
| alloc_vc | input | 4 | Channel number for the single allocation |
| alloc_cnt | input | 7 | Slot count for the single allocation |
| batch_req | input | 1 | Batch allocation request |
| strm_en | input | 4 | Bit i enables stream i in a batch |
| strm_cnt | input | 28 | Slot count of stream i in bits [i*7 +: 7] |
| clr_req | input | 1 | Clear-all request |
| peer_stat | input | 2 | Far-end status: bit 0 table updated, bit 1 trigger seen |
| rd_slot | input | 6 | Slot index for the read port |
| busy | output | 1 | An operation is in progress |
| done | output | 1 | One-cycle pulse at the end of an operation |
| fail_code | output | 2 | 0 none, 1 no free slot, 2 not enough room |
| start_slot | output | 6 | Start slot of the last evaluated allocation |
| strm_start | output | 24 | Start slot of stream i in bits [i*6 +: 6] |
| act_req | output | 1 | Activation trigger |
| rd_vc | output | 4 | Channel number held in slot rd_slot |

## Verification
The hardest case to reach is a batch that fails part-way: the map must already hold allocations so that an early stream fits and a later one runs out of room at the very top of the table, and the bench must then show that the earlier stream was written, the later one was not, and no trigger followed. The stimulus builds this by clearing, placing a short run, and issuing a batch whose first count lands exactly on slot 62 so that the second stream finds a single free slot at 63. Capacity boundaries (a request one slot too large, a request that fills to slot 63, a full table) are built the same way through preceding allocations, and a late far-end update is driven so the trigger waits in the update phase.

// File: rtl/tslot_pkg.sv
package tslot_pkg;

    // result of the most recent request
    typedef enum logic [1:0] {
        FAIL_NONE   = 2'd0,
        FAIL_NOFREE = 2'd1,
        FAIL_SMALL  = 2'd2
    } fail_e;

    // sequencer states
    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_PICK = 3'd1,
        ST_EVAL = 3'd2,
        ST_CLR  = 3'd3,
        ST_UPD  = 3'd4,
        ST_ACT  = 3'd5,
        ST_DONE = 3'd6
    } state_e;

    // bit positions of the far-end status word
    localparam int STAT_UPD_BIT = 0;
    localparam int STAT_ACT_BIT = 1;

endpackage

// File: rtl/tslot_table.sv
module tslot_table #(
    parameter int NUM_SLOTS = 64,
    parameter int VC_W      = 4,
    parameter int SLOT_W    = 6,
    parameter int CNT_W     = 7
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 clr,
    input  logic                 fill,
    input  logic [SLOT_W-1:0]    fill_start,
    input  logic [CNT_W-1:0]     fill_cnt,
    input  logic [VC_W-1:0]      fill_vc,
    input  logic [SLOT_W-1:0]    rd_slot,
    output logic [VC_W-1:0]      rd_vc,
    output logic [NUM_SLOTS-1:0] free_vec
);
    localparam int SUM_W = CNT_W + 1;

    logic [VC_W-1:0]  ent [NUM_SLOTS];
    logic [SUM_W-1:0] run_lo;
    logic [SUM_W-1:0] run_hi;

    assign run_lo = SUM_W'(fill_start);
    assign run_hi = SUM_W'(fill_start) + SUM_W'(fill_cnt);

    for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
        if (s == 0) begin : g_rsvd
            // reserved slot: permanently unowned and never offered
            assign ent[s]      = '0;
            assign free_vec[s] = 1'b0;
        end else begin : g_live
            logic [VC_W-1:0] q;
            logic            hit;
            assign hit = (SUM_W'(s) >= run_lo) && (SUM_W'(s) < run_hi);
            always_ff @(posedge clk) begin
                if (rst || clr) begin
                    q <= '0;
                end else if (fill && hit) begin
                    q <= fill_vc;
                end
            end
            assign ent[s]      = q;
            assign free_vec[s] = (q == '0);
        end
    end

    assign rd_vc = ent[rd_slot];

endmodule

// File: rtl/tslot_search.sv
module tslot_search #(
    parameter int NUM_SLOTS = 64,
    parameter int SLOT_W    = 6
) (
    input  logic [NUM_SLOTS-1:0] free_vec,
    output logic                 any_free,
    output logic [SLOT_W-1:0]    first_free
);
    // lowest set bit wins: scan downward so the last hit is the lowest
    always_comb begin
        first_free = '0;
        for (int i = NUM_SLOTS - 1; i >= 0; i--) begin
            if (free_vec[i]) begin
                first_free = SLOT_W'(i);
            end
        end
    end

    assign any_free = |free_vec;

endmodule

// File: rtl/tslot_act.sv
module tslot_act (
    input  logic clk,
    input  logic rst,
    input  logic go,
    input  logic ack,
    output logic act_req,
    output logic fin
);
    always_ff @(posedge clk) begin
        if (rst) begin
            act_req <= 1'b0;
        end else if (go) begin
            act_req <= 1'b1;
        end else if (act_req && ack) begin
            act_req <= 1'b0;
        end
    end

    assign fin = act_req && ack;

endmodule

// File: rtl/tslot_alloc.sv
module tslot_alloc
    import tslot_pkg::*;
#(
    parameter int NUM_SLOTS = 64,
    parameter int VC_W      = 4,
    parameter int NSTREAM   = 4,
    localparam int SLOT_W   = $clog2(NUM_SLOTS),
    localparam int CNT_W    = SLOT_W + 1
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      alloc_req,
    input  logic [VC_W-1:0]           alloc_vc,
    input  logic [CNT_W-1:0]          alloc_cnt,
    input  logic                      batch_req,
    input  logic [NSTREAM-1:0]        strm_en,
    input  logic [NSTREAM*CNT_W-1:0]  strm_cnt,
    input  logic                      clr_req,
    input  logic [1:0]                peer_stat,
    input  logic [SLOT_W-1:0]         rd_slot,
    output logic                      busy,
    output logic                      done,
    output logic [1:0]                fail_code,
    output logic [SLOT_W-1:0]         start_slot,
    output logic [NSTREAM*SLOT_W-1:0] strm_start,
    output logic                      act_req,
    output logic [VC_W-1:0]           rd_vc
);
    localparam int IDX_W = (NSTREAM > 1) ? $clog2(NSTREAM) : 1;
    localparam int SUM_W = CNT_W + 1;

    state_e             state_q;
    fail_e              fail_q;
    logic [NSTREAM-1:0] pend_q;
    logic [VC_W-1:0]    vc_q    [NSTREAM];
    logic [CNT_W-1:0]   cnt_q   [NSTREAM];
    logic [SLOT_W-1:0]  sstart_q[NSTREAM];
    logic [IDX_W-1:0]   cur_q;
    logic               single_q;
    logic [SLOT_W-1:0]  start_q;

    logic [NUM_SLOTS-1:0] free_vec;
    logic                 any_free;
    logic [SLOT_W-1:0]    first_free;
    logic [IDX_W-1:0]     pick_idx;
    logic [CNT_W-1:0]     cur_cnt;
    logic [VC_W-1:0]      cur_vc;
    logic [SUM_W-1:0]     room;
    logic                 too_small;
    logic                 fill_en;
    logic                 clr_en;
    logic                 act_go;
    logic                 act_fin;

    // lowest pending stream goes first
    always_comb begin
        pick_idx = '0;
        for (int i = NSTREAM - 1; i >= 0; i--) begin
            if (pend_q[i]) begin
                pick_idx = IDX_W'(i);
            end
        end
    end

    assign cur_cnt   = cnt_q[cur_q];
    assign cur_vc    = vc_q[cur_q];
    assign room      = SUM_W'(NUM_SLOTS) - SUM_W'(first_free);
    assign too_small = SUM_W'(cur_cnt) > room;
    assign fill_en   = (state_q == ST_EVAL) && any_free && !too_small;
    assign clr_en    = (state_q == ST_CLR);
    assign act_go    = (state_q == ST_UPD) && peer_stat[STAT_UPD_BIT];

    tslot_table #(
        .NUM_SLOTS (NUM_SLOTS),
        .VC_W      (VC_W),
        .SLOT_W    (SLOT_W),
        .CNT_W     (CNT_W)
    ) u_table (
        .clk        (clk),
        .rst        (rst),
        .clr        (clr_en),
        .fill       (fill_en),
        .fill_start (first_free),
        .fill_cnt   (cur_cnt),
        .fill_vc    (cur_vc),
        .rd_slot    (rd_slot),
        .rd_vc      (rd_vc),
        .free_vec   (free_vec)
    );

    tslot_search #(
        .NUM_SLOTS (NUM_SLOTS),
        .SLOT_W    (SLOT_W)
    ) u_search (
        .free_vec   (free_vec),
        .any_free   (any_free),
        .first_free (first_free)
    );

    tslot_act u_act (
        .clk     (clk),
        .rst     (rst),
        .go      (act_go),
        .ack     (peer_stat[STAT_ACT_BIT]),
        .act_req (act_req),
        .fin     (act_fin)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= ST_IDLE;
            fail_q   <= FAIL_NONE;
            pend_q   <= '0;
            cur_q    <= '0;
            single_q <= 1'b0;
            start_q  <= '0;
            for (int i = 0; i < NSTREAM; i++) begin
                vc_q[i]     <= '0;
                cnt_q[i]    <= '0;
                sstart_q[i] <= '0;
            end
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (clr_req) begin
                        fail_q  <= FAIL_NONE;
                        state_q <= ST_CLR;
                    end else if (batch_req) begin
                        fail_q   <= FAIL_NONE;
                        single_q <= 1'b0;
                        pend_q   <= strm_en;
                        for (int i = 0; i < NSTREAM; i++) begin
                            vc_q[i]  <= VC_W'(i + 1);
                            cnt_q[i] <= strm_cnt[i*CNT_W +: CNT_W];
                        end
                        state_q <= ST_PICK;
                    end else if (alloc_req) begin
                        fail_q   <= FAIL_NONE;
                        single_q <= 1'b1;
                        pend_q   <= NSTREAM'(1);
                        vc_q[0]  <= alloc_vc;
                        cnt_q[0] <= alloc_cnt;
                        state_q  <= ST_PICK;
                    end
                end
                ST_PICK: begin
                    if (pend_q == '0) begin
                        state_q <= ST_UPD;
                    end else begin
                        cur_q            <= pick_idx;
                        pend_q[pick_idx] <= 1'b0;
                        state_q          <= ST_EVAL;
                    end
                end
                ST_EVAL: begin
                    if (!any_free) begin
                        fail_q  <= FAIL_NOFREE;
                        start_q <= '0;
                        state_q <= ST_DONE;
                    end else if (too_small) begin
                        fail_q  <= FAIL_SMALL;
                        start_q <= first_free;
                        state_q <= ST_DONE;
                    end else begin
                        start_q <= first_free;
                        if (!single_q) begin
                            sstart_q[cur_q] <= first_free;
                        end
                        state_q <= ST_PICK;
                    end
                end
                ST_CLR: begin
                    state_q <= ST_UPD;
                end
                ST_UPD: begin
                    if (peer_stat[STAT_UPD_BIT]) begin
                        state_q <= ST_ACT;
                    end
                end
                ST_ACT: begin
                    if (act_fin) begin
                        state_q <= ST_DONE;
                    end
                end
                ST_DONE: begin
                    state_q <= ST_IDLE;
                end
                default: begin
                    state_q <= ST_IDLE;
                end
            endcase
        end
    end

    for (genvar i = 0; i < NSTREAM; i++) begin : g_sout
        assign strm_start[i*SLOT_W +: SLOT_W] = sstart_q[i];
    end

    assign busy       = (state_q != ST_IDLE);
    assign done       = (state_q == ST_DONE);
    assign fail_code  = fail_q;
    assign start_slot = start_q;

endmodule

// File: rtl/tslot_alloc_chk.sv
module tslot_alloc_chk #(
    parameter int SLOT_W = 6
) (
    input logic              clk,
    input logic              rst,
    input logic              busy,
    input logic              done,
    input logic [1:0]        fail_code,
    input logic [SLOT_W-1:0] start_slot,
    input logic [1:0]        peer_stat,
    input logic              act_req
);
    // R9
    act_hold_chk: assert property (@(posedge clk) disable iff (rst)
        act_req && !peer_stat[1] |=> act_req);

    // R9
    act_after_upd_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(act_req) |-> $past(peer_stat[0]));

    // R10
    done_in_busy_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> busy);

    // R10
    busy_ends_done_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> $past(done));

    // R5
    fail_no_act_chk: assert property (@(posedge clk) disable iff (rst)
        (fail_code != 2'd0) |-> !act_req);

    // R6
    nofree_zero_chk: assert property (@(posedge clk) disable iff (rst)
        done && (fail_code == 2'd1) |-> (start_slot == '0));

    // R2
    small_nonzero_chk: assert property (@(posedge clk) disable iff (rst)
        (fail_code == 2'd2) |-> (start_slot != '0));

endmodule

bind tslot_alloc tslot_alloc_chk #(.SLOT_W(SLOT_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .busy       (busy),
    .done       (done),
    .fail_code  (fail_code),
    .start_slot (start_slot),
    .peer_stat  (peer_stat),
    .act_req    (act_req)
);

// File: tb/tslot_alloc_bench.sv
module tslot_alloc_bench;
    localparam int CLK_PERIOD = 10;
    localparam int NS  = 64;
    localparam int NST = 4;
    localparam int CW  = 7;
    localparam int SW  = 6;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          alloc_req = 1'b0;
    logic [3:0]    alloc_vc  = '0;
    logic [CW-1:0] alloc_cnt = '0;
    logic          batch_req = 1'b0;
    logic [3:0]    strm_en   = '0;
    logic [27:0]   strm_cnt  = '0;
    logic          clr_req   = 1'b0;
    logic [1:0]    peer_stat = '0;
    logic [SW-1:0] rd_slot   = '0;
    logic          busy, done, act_req;
    logic [1:0]    fail_code;
    logic [SW-1:0] start_slot;
    logic [23:0]   strm_start;
    logic [3:0]    rd_vc;

    tslot_alloc u_tslot_alloc (
        .clk(clk), .rst(rst), .alloc_req(alloc_req), .alloc_vc(alloc_vc),
        .alloc_cnt(alloc_cnt), .batch_req(batch_req), .strm_en(strm_en),
        .strm_cnt(strm_cnt), .clr_req(clr_req), .peer_stat(peer_stat),
        .rd_slot(rd_slot), .busy(busy), .done(done), .fail_code(fail_code),
        .start_slot(start_slot), .strm_start(strm_start), .act_req(act_req),
        .rd_vc(rd_vc)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int checks = 0;
    int errors = 0;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    int mp;             // 0 idle 1 pick 2 eval 3 clear 4 wait update 5 trigger 6 done
    int mtab[NS];
    int mq[$];
    int mvc[NST];
    int mcnt[NST];
    bit msingle;
    int mcur;
    int mstart;
    int mfail;
    int mstrm[NST];
    bit mact;

    always @(posedge clk) begin
        if (rst) begin
            mp = 0; mact = 0; mstart = 0; mfail = 0; msingle = 0; mcur = 0;
            mq.delete();
            for (int k = 0; k < NS; k++) mtab[k] = 0;
            for (int k = 0; k < NST; k++) begin mstrm[k] = 0; mvc[k] = 0; mcnt[k] = 0; end
        end else begin
            case (mp)
                0: begin
                    if (clr_req) begin
                        mfail = 0; mp = 3;
                    end else if (batch_req) begin
                        mfail = 0; msingle = 0; mq.delete();
                        for (int k = 0; k < NST; k++) begin
                            mvc[k]  = k + 1;
                            mcnt[k] = int'(strm_cnt[k*CW +: CW]);
                            if (strm_en[k]) mq.push_back(k);
                        end
                        mp = 1;
                    end else if (alloc_req) begin
                        mfail = 0; msingle = 1; mq.delete(); mq.push_back(0);
                        mvc[0] = int'(alloc_vc); mcnt[0] = int'(alloc_cnt);
                        mp = 1;
                    end
                end
                1: begin
                    if (mq.size() == 0) mp = 4;
                    else begin mcur = mq.pop_front(); mp = 2; end
                end
                2: begin
                    int s;
                    s = 0;
                    for (int k = NS - 1; k >= 1; k--) if (mtab[k] == 0) s = k;
                    if (s == 0) begin
                        mfail = 1; mstart = 0; mp = 6;
                    end else if (NS - s < mcnt[mcur]) begin
                        mfail = 2; mstart = s; mp = 6;
                    end else begin
                        for (int k = s; k < s + mcnt[mcur]; k++) mtab[k] = mvc[mcur];
                        mstart = s;
                        if (!msingle) mstrm[mcur] = s;
                        mp = 1;
                    end
                end
                3: begin
                    for (int k = 0; k < NS; k++) mtab[k] = 0;
                    mp = 4;
                end
                4: if (peer_stat[0]) begin mact = 1; mp = 5; end
                5: if (peer_stat[1]) begin mact = 0; mp = 6; end
                default: mp = 0;
            endcase
        end
    end

    // per-cycle comparison, away from both edges
    always @(negedge clk) begin
        #2;
        if (!rst) begin
            chk(busy == (mp != 0), "R10 busy", int'(busy), int'(mp != 0));
            chk(done == (mp == 6), "R9 done", int'(done), int'(mp == 6));
            chk(act_req == mact, "R9 act_req", int'(act_req), int'(mact));
            chk(int'(rd_vc) == mtab[rd_slot], "R11 rd_vc", int'(rd_vc), mtab[rd_slot]);
            chk(int'(start_slot) == mstart, "R3 start_slot", int'(start_slot), mstart);
            chk(int'(fail_code) == mfail, "R5 fail_code", int'(fail_code), mfail);
            for (int k = 0; k < NST; k++)
                chk(int'(strm_start[k*SW +: SW]) == mstrm[k], "R8 strm_start",
                    int'(strm_start[k*SW +: SW]), mstrm[k]);
        end
    end

    // ---------------- far-end responder ----------------
    int  dly_upd = 2;
    int  dly_act = 3;
    int  rcnt, acnt;
    bit  act_seen;
    bit  sweep_on = 1'b1;

    always @(negedge clk) begin
        if (rst || !busy) begin
            peer_stat = 2'b00; rcnt = 0; acnt = 0;
        end else begin
            rcnt++;
            if (rcnt >= dly_upd) peer_stat[0] = 1'b1;
            if (act_req) begin
                act_seen = 1'b1;
                acnt++;
                if (acnt >= dly_act) peer_stat[1] = 1'b1;
            end
        end
        if (sweep_on) rd_slot = rd_slot + 1'b1;
    end

    // ---------------- watchdog ----------------
    int cyc = 0;
    always @(posedge clk) begin
        cyc++;
        if (cyc > 50000) begin
            checks++; errors++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 50000);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    // ---------------- stimulus helpers ----------------
    int r_fail, r_start;
    bit r_act;

    task automatic wait_done();
        do @(negedge clk); while (!done);
        r_fail  = int'(fail_code);
        r_start = int'(start_slot);
        r_act   = act_seen;
        @(negedge clk);
    endtask

    task automatic go_alloc(input int vc, input int cnt);
        @(negedge clk);
        act_seen = 0; alloc_vc = 4'(vc); alloc_cnt = CW'(cnt); alloc_req = 1;
        @(negedge clk);
        alloc_req = 0;
        wait_done();
    endtask

    function automatic logic [27:0] pack_cnt(input int c0, input int c1, input int c2, input int c3);
        return {CW'(c3), CW'(c2), CW'(c1), CW'(c0)};
    endfunction

    task automatic go_batch(input logic [3:0] en, input logic [27:0] cn);
        @(negedge clk);
        act_seen = 0; strm_en = en; strm_cnt = cn; batch_req = 1;
        @(negedge clk);
        batch_req = 0;
        wait_done();
    endtask

    task automatic rd(input int s, output int v);
        @(negedge clk);
        sweep_on = 0;
        rd_slot  = SW'(s);
        #1 v = int'(rd_vc);
        sweep_on = 1;
    endtask

    int v;

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);

        // R1 reset state
        chk(busy == 0, "R1 busy after reset", int'(busy), 0);
        chk(act_req == 0, "R1 act_req after reset", int'(act_req), 0);
        rd(1, v);  chk(v == 0, "R1 slot1 after reset", v, 0);
        rd(63, v); chk(v == 0, "R1 slot63 after reset", v, 0);

        // R2 R4 first allocation starts at slot 1
        go_alloc(1, 5);
        chk(r_start == 1, "R2 first start", r_start, 1);
        chk(r_fail == 0, "R4 success code", r_fail, 0);
        chk(r_act == 1, "R9 trigger after alloc", int'(r_act), 1);
        rd(0, v); chk(v == 0, "R2 slot0 reserved", v, 0);
        rd(5, v); chk(v == 1, "R4 last slot of run", v, 1);
        rd(6, v); chk(v == 0, "R4 slot past run", v, 0);

        // R12 zero count
        go_alloc(2, 0);
        chk(r_start == 6, "R12 zero-count start", r_start, 6);
        rd(6, v); chk(v == 0, "R12 zero-count no write", v, 0);

        // R3 next free, late far-end update
        dly_upd = 12;
        go_alloc(2, 10);
        dly_upd = 2;
        chk(r_start == 6, "R3 next free start", r_start, 6);
        rd(15, v); chk(v == 2, "R4 second run end", v, 2);

        // R5 one slot too many
        go_alloc(3, 49);
        chk(r_fail == 2, "R5 too-small code", r_fail, 2);
        chk(r_start == 16, "R5 too-small start", r_start, 16);
        chk(r_act == 0, "R5 no trigger on fail", int'(r_act), 0);
        rd(16, v); chk(v == 0, "R5 table untouched", v, 0);

        // R4 exact fit to top
        go_alloc(3, 48);
        chk(r_fail == 0, "R4 exact fit code", r_fail, 0);
        rd(63, v); chk(v == 3, "R4 top slot filled", v, 3);

        // R6 full table
        go_alloc(4, 0);
        chk(r_fail == 1, "R6 no-free code", r_fail, 1);
        chk(r_start == 0, "R6 no-free start", r_start, 0);

        // R7 R10 clear with a request arriving while busy
        @(negedge clk);
        act_seen = 0; clr_req = 1;
        @(negedge clk);
        clr_req = 0; alloc_vc = 4'd5; alloc_cnt = 7'd3; alloc_req = 1;
        @(negedge clk);
        alloc_req = 0;
        wait_done();
        chk(r_act == 1, "R7 trigger after clear", int'(r_act), 1);
        rd(1, v);  chk(v == 0, "R10 busy request ignored / R7 slot1", v, 0);
        rd(63, v); chk(v == 0, "R7 slot63 cleared", v, 0);

        // R8 batch, stream 3 disabled
        go_batch(4'b1011, pack_cnt(3, 4, 7, 2));
        chk(int'(strm_start[0 +: SW]) == 1, "R8 stream1 start", int'(strm_start[0 +: SW]), 1);
        chk(int'(strm_start[6 +: SW]) == 4, "R8 stream2 start", int'(strm_start[6 +: SW]), 4);
        chk(int'(strm_start[18 +: SW]) == 8, "R8 stream4 start", int'(strm_start[18 +: SW]), 8);
        rd(7, v);  chk(v == 2, "R8 stream2 channel", v, 2);
        rd(9, v);  chk(v == 4, "R8 stream4 channel", v, 4);
        rd(10, v); chk(v == 0, "R8 nothing past batch", v, 0);

        // R13 clear beats single allocation
        @(negedge clk);
        act_seen = 0; clr_req = 1; alloc_req = 1; alloc_vc = 4'd7; alloc_cnt = 7'd5;
        @(negedge clk);
        clr_req = 0; alloc_req = 0;
        wait_done();
        rd(1, v); chk(v == 0, "R13 clear wins", v, 0);

        // R13 batch beats single allocation
        @(negedge clk);
        act_seen = 0; batch_req = 1; strm_en = 4'b0001; strm_cnt = pack_cnt(2, 0, 0, 0);
        alloc_req = 1; alloc_vc = 4'd7; alloc_cnt = 7'd5;
        @(negedge clk);
        batch_req = 0; alloc_req = 0;
        wait_done();
        rd(2, v); chk(v == 1, "R13 batch wins", v, 1);
        rd(3, v); chk(v == 0, "R13 single dropped", v, 0);

        // R8 R5 batch failing on its second stream
        go_batch(4'b1111, pack_cnt(60, 5, 1, 1));
        chk(r_fail == 2, "R8 batch stops on too-small", r_fail, 2);
        chk(r_start == 63, "R5 failing stream start", r_start, 63);
        chk(r_act == 0, "R8 no trigger after failed batch", int'(r_act), 0);
        chk(int'(strm_start[0 +: SW]) == 3, "R8 stream1 placed", int'(strm_start[0 +: SW]), 3);
        rd(62, v); chk(v == 1, "R8 earlier stream kept", v, 1);
        rd(63, v); chk(v == 0, "R8 failing stream not written", v, 0);

        repeat (3) @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule